// File: doc/BRIEF.md
# Indexed Gather-Scatter Address Sequencer

This block turns one vector indexed memory operation into a stream of memory requests. It takes a scalar base address, a packed vector of offsets, and for stores a packed vector of data. It also takes the active element count, the data element width and a separately chosen offset element width. It presents one request per group of elements on a valid/ready port. For loads it collects tagged responses, which may come back in any order, into a destination vector. A one-cycle completion pulse marks the end of the operation.

Two issue policies are offered. The ordered policy emits exactly one request per element, in rising element order. For loads it also holds back each request until the previous response has returned, so memory sees the accesses strictly from element 0 upward. The unordered policy folds a run of consecutive elements that fall in one 8-byte aligned word into a single request, and so trades visible access order for fewer transactions.

The controller is a five-state machine. IDLE waits for `start`. It goes to DONE when the element count is zero and to ISSUE otherwise. ISSUE drives the request port. On each acceptance it advances the element pointer. After the final acceptance it goes to DONE for stores and to DRAIN for loads. After a non-final acceptance of an ordered load it goes to WAIT1. WAIT1 returns to ISSUE when the response arrives. DRAIN goes to DONE once every element of a load has been answered. DONE raises `done` for one cycle and returns to IDLE.

Top module: `gather_scatter_seq`

## Requirements
- R1: While reset is asserted and directly after it, `busy`, `done` and `req_valid` are 0.
- R2: Element k's byte address is `base_addr` plus the k-th offset, treated as unsigned and zero-extended. Addresses are assumed naturally aligned to the data width. Each request carries the element's address rounded down to a multiple of 8 on `req_addr`. `req_be` bit b is set for each byte of the element at lane (address mod 8) + b.
- R3: The offset width and the data width are chosen independently, each with code 0/1/2/3 meaning 8/16/32/64 bits. Offset k sits at bit position k times the offset width in `idx_vec`. Data element k sits at k times the data width in `src_vec` and `dst_vec`.
- R4: A store request carries each covered element's data bytes from `src_vec` in the lanes it enables, with zeros in the other lanes, and has `req_we`=1. Load requests have `req_we`=0.
- R5: In ordered mode every request covers one element, and requests appear in rising element order. For loads, no request is presented while an earlier load response is outstanding.
- R6: In unordered mode a request starting at element k also covers k+1, k+2, ... for as long as they are active and lie in the same aligned word as element k. `req_be` is the union of their lanes. Where lanes overlap, the higher-numbered element's data wins.
- R7: `req_tag` is the number of the first element covered. A response with tag t writes every element of that request into `dst_vec`, taken from `rsp_data` at the element's lane. Responses may arrive in any order. `dst_vec` is cleared when a load starts.
- R8: `done` is high for exactly one cycle. That cycle is the one after the final store acceptance or after the final load response. `busy` is 0 while `done` is high.
- R9: With an active element count of 0, no request is made, and `done` rises the cycle after `start`.
- R10: `start` is ignored unless the block is idle (`busy`=0, `done`=0).
- R11: A request that is held by `req_ready`=0 keeps `req_valid`, `req_addr`, `req_be` and `req_wdata` unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op_store | input | 1 | 1 = scatter (store), 0 = gather (load) |
| op_ordered | input | 1 | 1 = ordered issue, 0 = unordered with merging |
| base_addr | input | AW | Scalar base address |
| idx_vec | input | NE*64 | Packed offset vector |
| src_vec | input | NE*64 | Packed store data vector |
| vlen | input | $clog2(NE+1) | Active element count |
| data_wsel | input | 2 | Data width code |
| idx_wsel | input | 2 | Offset width code |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory request accepted |
| req_we | output | 1 | Request is a write |
| req_addr | output | AW | 8-byte aligned word address |
| req_be | output | 8 | Byte lanes touched |
| req_wdata | output | 64 | Write data, lane-positioned |
| req_tag | output | $clog2(NE) | First element number in the request |
| rsp_valid | input | 1 | Load response valid |
| rsp_tag | input | $clog2(NE) | Tag of the answered request |
| rsp_data | input | 64 | Word read from memory |
| dst_vec | output | NE*64 | Packed load result vector |

## Verification
Stores and loads are run under both policies. Each run uses a different pair of offset and data widths, so a swapped width selection or a wrong field stride shows up as a wrong address or lane. Offsets are chosen so that some consecutive elements share a word and some do not. Duplicate offsets make merged store lanes overlap, which separates "higher element wins" from "lower element wins" and merging from one-per-element issue. A large 8-bit offset separates zero-extension from sign-extension. A last-in-first-out responder and a toggling `req_ready` stress out-of-order write-back and request holding. A zero-length operation and a second `start` during a busy run cover the corner cases of the controller.

// File: rtl/gss_pkg.sv
package gss_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT1,
        S_DRAIN,
        S_DONE
    } gss_state_e;

    // Byte count of an element for a 2-bit width code (8/16/32/64 bits).
    function automatic logic [3:0] wbytes(input logic [1:0] wsel);
        return 4'(4'd1 << wsel);
    endfunction

    // Lane mask of an element placed at lane 0.
    function automatic logic [7:0] lane_mask(input logic [1:0] wsel);
        return 8'((16'd1 << wbytes(wsel)) - 16'd1);
    endfunction

    // Bit mask of an element value.
    function automatic logic [63:0] val_mask(input logic [1:0] wsel);
        logic [63:0] m;
        if (wsel == 2'd3) m = '1;
        else              m = (64'd1 << (7'd8 << wsel)) - 64'd1;
        return m;
    endfunction

endpackage

// File: rtl/gss_elem.sv
module gss_elem
    import gss_pkg::*;
#(
    parameter int AW = 32,
    parameter int VB = 512,
    parameter int K  = 0
) (
    input  logic [AW-1:0] base,
    input  logic [VB-1:0] idx_vec,
    input  logic [VB-1:0] src_vec,
    input  logic [1:0]    iw,
    input  logic [1:0]    dw,
    output logic [AW-1:0] addr,
    output logic [7:0]    be,
    output logic [63:0]   lane
);
    logic [63:0] ix;
    logic [63:0] dv;

    always_comb begin
        // Fields are located by element number times their own width.
        ix   = 64'(idx_vec >> ((K * 8) << iw)) & val_mask(iw);
        dv   = 64'(src_vec >> ((K * 8) << dw)) & val_mask(dw);
        addr = base + ix[AW-1:0];
        be   = 8'(lane_mask(dw) << addr[2:0]);
        lane = dv << {addr[2:0], 3'b000};
    end
endmodule

// File: rtl/gss_merge.sv
module gss_merge #(
    parameter int NE = 8,
    parameter int AW = 32,
    parameter int LW = 4
) (
    input  logic [LW-1:0] cur,
    input  logic [LW-1:0] vlen,
    input  logic          ordered,
    input  logic [AW-1:0] el_addr [NE],
    input  logic [7:0]    el_be   [NE],
    input  logic [63:0]   el_lane [NE],
    output logic [LW-1:0] run_len,
    output logic [AW-1:0] m_addr,
    output logic [7:0]    m_be,
    output logic [63:0]   m_wdata
);
    logic [AW-4:0] head_word;
    logic          cont;
    logic [LW:0]   run_end;

    always_comb begin
        head_word = '0;
        for (int j = 0; j < NE; j++) begin
            if (LW'(j) == cur) head_word = el_addr[j][AW-1:3];
        end

        // Extend the run while consecutive active elements share the word.
        run_len = LW'(1);
        cont    = 1'b1;
        for (int j = 0; j < NE; j++) begin
            if (LW'(j) > cur) begin
                if (cont && !ordered && LW'(j) < vlen &&
                    el_addr[j][AW-1:3] == head_word)
                    run_len = run_len + LW'(1);
                else
                    cont = 1'b0;
            end
        end

        run_end = {1'b0, cur} + {1'b0, run_len};
        m_be    = '0;
        m_wdata = '0;
        // Rising element order: a later element overwrites shared lanes.
        for (int j = 0; j < NE; j++) begin
            if (LW'(j) >= cur && (LW + 1)'(j) < run_end) begin
                m_be = m_be | el_be[j];
                for (int b = 0; b < 8; b++) begin
                    if (el_be[j][b]) m_wdata[b*8 +: 8] = el_lane[j][b*8 +: 8];
                end
            end
        end
        m_addr = {head_word, 3'b000};
    end
endmodule

// File: rtl/gss_unpack.sv
module gss_unpack
    import gss_pkg::*;
#(
    parameter int NE = 8,
    parameter int AW = 32,
    parameter int LW = 4,
    parameter int TW = 3,
    parameter int VB = 512
) (
    input  logic          en,
    input  logic [TW-1:0] tag,
    input  logic [LW-1:0] cnt,
    input  logic [63:0]   data,
    input  logic [AW-1:0] el_addr [NE],
    input  logic [1:0]    dw,
    input  logic [VB-1:0] cur_vec,
    output logic [VB-1:0] nxt_vec
);
    logic [63:0] val;
    logic [LW:0] last_ex;
    int          sh;

    always_comb begin
        nxt_vec = cur_vec;
        val     = '0;
        sh      = 0;
        last_ex = {1'b0, LW'(tag)} + {1'b0, cnt};
        for (int j = 0; j < NE; j++) begin
            if (en && LW'(j) >= LW'(tag) && (LW + 1)'(j) < last_ex) begin
                val     = (data >> {el_addr[j][2:0], 3'b000}) & val_mask(dw);
                sh      = (j * 8) << dw;
                nxt_vec = (nxt_vec & ~(VB'(val_mask(dw)) << sh)) | (VB'(val) << sh);
            end
        end
    end
endmodule

// File: rtl/gather_scatter_seq.sv
module gather_scatter_seq
    import gss_pkg::*;
#(
    parameter int NE = 8,
    parameter int AW = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    op_store,
    input  logic                    op_ordered,
    input  logic [AW-1:0]           base_addr,
    input  logic [NE*64-1:0]        idx_vec,
    input  logic [NE*64-1:0]        src_vec,
    input  logic [$clog2(NE+1)-1:0] vlen,
    input  logic [1:0]              data_wsel,
    input  logic [1:0]              idx_wsel,
    output logic                    busy,
    output logic                    done,
    output logic                    req_valid,
    input  logic                    req_ready,
    output logic                    req_we,
    output logic [AW-1:0]           req_addr,
    output logic [7:0]              req_be,
    output logic [63:0]             req_wdata,
    output logic [$clog2(NE)-1:0]   req_tag,
    input  logic                    rsp_valid,
    input  logic [$clog2(NE)-1:0]   rsp_tag,
    input  logic [63:0]             rsp_data,
    output logic [NE*64-1:0]        dst_vec
);
    localparam int VB = NE * 64;
    localparam int TW = $clog2(NE);
    localparam int LW = $clog2(NE + 1);

    gss_state_e state_q, state_d;

    logic [AW-1:0] base_q;
    logic [VB-1:0] idx_q, src_q, dst_q, dst_nx;
    logic [LW-1:0] vl_q, cur_q, cur_nx, rsp_cnt_q, rsp_cnt_nx, run_len;
    logic [1:0]    dw_q, iw_q;
    logic          st_q, ord_q, rsp_take;
    logic [LW-1:0] cnt_tab [NE];

    logic [AW-1:0] el_addr [NE];
    logic [7:0]    el_be   [NE];
    logic [63:0]   el_lane [NE];
    logic [AW-1:0] m_addr;
    logic [7:0]    m_be;
    logic [63:0]   m_wdata;

    for (genvar g = 0; g < NE; g++) begin : g_elem
        gss_elem #(.AW(AW), .VB(VB), .K(g)) u_elem (
            .base    (base_q),
            .idx_vec (idx_q),
            .src_vec (src_q),
            .iw      (iw_q),
            .dw      (dw_q),
            .addr    (el_addr[g]),
            .be      (el_be[g]),
            .lane    (el_lane[g])
        );
    end

    gss_merge #(.NE(NE), .AW(AW), .LW(LW)) u_merge (
        .cur     (cur_q),
        .vlen    (vl_q),
        .ordered (ord_q),
        .el_addr (el_addr),
        .el_be   (el_be),
        .el_lane (el_lane),
        .run_len (run_len),
        .m_addr  (m_addr),
        .m_be    (m_be),
        .m_wdata (m_wdata)
    );

    assign rsp_take = rsp_valid && !st_q &&
                      (state_q == S_ISSUE || state_q == S_WAIT1 || state_q == S_DRAIN);

    gss_unpack #(.NE(NE), .AW(AW), .LW(LW), .TW(TW), .VB(VB)) u_unpack (
        .en      (rsp_take),
        .tag     (rsp_tag),
        .cnt     (cnt_tab[rsp_tag]),
        .data    (rsp_data),
        .el_addr (el_addr),
        .dw      (dw_q),
        .cur_vec (dst_q),
        .nxt_vec (dst_nx)
    );

    assign cur_nx     = cur_q + run_len;
    assign rsp_cnt_nx = rsp_cnt_q + (rsp_take ? cnt_tab[rsp_tag] : '0);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = (vlen == '0) ? S_DONE : S_ISSUE;
            S_ISSUE: begin
                if (req_ready) begin
                    if (cur_nx == vl_q)      state_d = st_q ? S_DONE : S_DRAIN;
                    else if (ord_q && !st_q) state_d = S_WAIT1;
                end
            end
            S_WAIT1: if (rsp_take) state_d = S_ISSUE;
            S_DRAIN: if (rsp_cnt_nx == vl_q) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Operand and progress registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q    <= '0;
            idx_q     <= '0;
            src_q     <= '0;
            dst_q     <= '0;
            vl_q      <= '0;
            cur_q     <= '0;
            rsp_cnt_q <= '0;
            dw_q      <= '0;
            iw_q      <= '0;
            st_q      <= 1'b0;
            ord_q     <= 1'b0;
            for (int i = 0; i < NE; i++) cnt_tab[i] <= '0;
        end else begin
            if (state_q == S_IDLE && start) begin
                base_q    <= base_addr;
                idx_q     <= idx_vec;
                src_q     <= src_vec;
                vl_q      <= vlen;
                dw_q      <= data_wsel;
                iw_q      <= idx_wsel;
                st_q      <= op_store;
                ord_q     <= op_ordered;
                cur_q     <= '0;
                rsp_cnt_q <= '0;
                if (!op_store) dst_q <= '0;
            end else begin
                if (state_q == S_ISSUE && req_ready) begin
                    cur_q                 <= cur_nx;
                    cnt_tab[cur_q[TW-1:0]] <= run_len;
                end
                if (rsp_take) begin
                    rsp_cnt_q <= rsp_cnt_nx;
                    dst_q     <= dst_nx;
                end
            end
        end
    end

    // Outputs from state
    always_comb begin
        busy      = 1'b0;
        done      = 1'b0;
        req_valid = 1'b0;
        unique case (state_q)
            S_IDLE:  ;
            S_ISSUE: begin busy = 1'b1; req_valid = 1'b1; end
            S_WAIT1: busy = 1'b1;
            S_DRAIN: busy = 1'b1;
            S_DONE:  done = 1'b1;
            default: ;
        endcase
        req_we    = st_q;
        req_addr  = m_addr;
        req_be    = m_be;
        req_wdata = st_q ? m_wdata : '0;
        req_tag   = cur_q[TW-1:0];
        dst_vec   = dst_q;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_be) && $stable(req_wdata)); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R8
    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_addr[2:0] == 3'b000 && req_be != 8'h00); // R2
    AST_ORD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && ord_q |-> $countones(req_be) == int'(wbytes(dw_q))); // R5
    AST_ORD_LOAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && ord_q && !req_we |=> !req_valid); // R5
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(st_q) && $stable(vl_q)); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !req_valid); // R9

endmodule

// File: tb/gather_scatter_seq_tb.sv
module gather_scatter_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 8;
    localparam int AW = 32;
    localparam int VB = NE * 64;
    localparam int TW = 3;
    localparam int LW = 4;

    typedef struct {
        logic [31:0] addr;
        logic [7:0]  be;
        logic [63:0] wd;
        logic        we;
        int          tag;
    } req_t;
    typedef struct {
        logic [31:0] addr;
        int          tag;
    } pend_t;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, op_store = 1'b0, op_ordered = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [VB-1:0] idx_vec = '0, src_vec = '0, dst_vec;
    logic [LW-1:0] vlen = '0;
    logic [1:0] data_wsel = '0, idx_wsel = '0;
    logic busy, done, req_valid, req_we;
    logic req_ready = 1'b1;
    logic [AW-1:0] req_addr;
    logic [7:0] req_be;
    logic [63:0] req_wdata;
    logic [TW-1:0] req_tag;
    logic rsp_valid = 1'b0;
    logic [TW-1:0] rsp_tag = '0;
    logic [63:0] rsp_data = '0;

    gather_scatter_seq #(.NE(NE), .AW(AW)) u_dut (.*);

    int checks = 0, fails = 0, cyc = 0, last_evt = 0;
    logic [7:0] mem [256];
    logic [63:0] ie [NE];
    logic [63:0] de [NE];
    req_t exp_q[$];
    pend_t pend_q[$];
    bit cur_ord = 0, cur_st = 0, lifo_m = 0, stall_m = 0, prev_stall = 0;
    logic [31:0] p_addr;
    logic [7:0] p_be;
    logic [63:0] p_wd;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] addr_of(input int k, input logic [31:0] b, input logic [1:0] iw);
        logic [63:0] v;
        v = (iw == 2'd3) ? ie[k] : (ie[k] & ((64'd1 << (8 << iw)) - 1));
        return b + v[31:0];
    endfunction

    // Monitor, responder and scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            pend_t p;
            req_t e;
            logic [63:0] w;
            if (cur_ord && !cur_st && req_valid && pend_q.size() != 0)
                chk(0, "R5 ordered load issued while response outstanding", 1, 0);
            rsp_valid = 1'b0;
            if (pend_q.size() != 0 && (!lifo_m || pend_q.size() >= 2 || !req_valid)) begin
                p = lifo_m ? pend_q.pop_back() : pend_q.pop_front();
                for (int b = 0; b < 8; b++) w[b*8 +: 8] = mem[8'(p.addr + 32'(b))];
                rsp_valid = 1'b1;
                rsp_tag   = TW'(p.tag);
                rsp_data  = w;
                last_evt  = cyc;
            end
            req_ready = stall_m ? ~req_ready : 1'b1;
            if (prev_stall)
                chk(req_valid && req_addr == p_addr && req_be == p_be && req_wdata == p_wd,
                    "R11 held request changed", {req_addr, req_be, 24'h0}, {p_addr, p_be, 24'h0});
            prev_stall = req_valid && !req_ready;
            p_addr = req_addr; p_be = req_be; p_wd = req_wdata;
            if (req_valid && req_ready) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R10 unexpected request", {32'h0, req_addr}, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(req_addr == e.addr, "R2 request address", {32'h0, req_addr}, {32'h0, e.addr});
                    chk(req_be == e.be, "R6 byte enables", {56'h0, req_be}, {56'h0, e.be});
                    chk(req_we == e.we, "R4 write flag", {63'h0, req_we}, {63'h0, e.we});
                    chk(int'(req_tag) == e.tag, "R7 request tag", {61'h0, req_tag}, 64'(e.tag));
                    if (e.we) begin
                        chk(req_wdata == e.wd, "R4 write data", req_wdata, e.wd);
                        for (int b = 0; b < 8; b++)
                            if (req_be[b]) mem[8'(req_addr + 32'(b))] = req_wdata[b*8 +: 8];
                        last_evt = cyc;
                    end else begin
                        p.addr = req_addr; p.tag = int'(req_tag);
                        pend_q.push_back(p);
                    end
                end
            end
        end
    end

    task automatic run_op(input bit st, input bit ord, input logic [31:0] b, input int vl,
                          input logic [1:0] dw, input logic [1:0] iw,
                          input bit lifo, input bit stall, input bit dbl);
        int eb, ib, k, n, t;
        bit seen;
        req_t e;
        logic [31:0] a, aj;
        logic [VB-1:0] exp_dst;
        eb = 1 << dw; ib = 1 << iw;
        idx_vec = '0; src_vec = '0; exp_dst = '0;
        for (int kk = 0; kk < NE; kk++) begin
            for (int bb = 0; bb < ib; bb++) idx_vec[(kk*ib+bb)*8 +: 8] = ie[kk][bb*8 +: 8];
            for (int bb = 0; bb < eb; bb++) src_vec[(kk*eb+bb)*8 +: 8] = de[kk][bb*8 +: 8];
        end
        // Expected request stream (driver side of the scoreboard)
        k = 0;
        while (k < vl) begin
            a = addr_of(k, b, iw);
            n = 1;
            if (!ord) while (k + n < vl && addr_of(k + n, b, iw) >> 3 == a >> 3) n++;
            e.addr = {a[31:3], 3'b000}; e.be = '0; e.wd = '0; e.we = st; e.tag = k;
            for (int j = k; j < k + n; j++) begin
                aj = addr_of(j, b, iw);
                for (int bb = 0; bb < eb; bb++) begin
                    e.be[aj[2:0] + 3'(bb)] = 1'b1;
                    e.wd[(aj[2:0] + 3'(bb))*8 +: 8] = de[j][bb*8 +: 8];
                end
            end
            exp_q.push_back(e);
            k += n;
        end
        if (!st)
            for (int j = 0; j < vl; j++) begin
                aj = addr_of(j, b, iw);
                for (int bb = 0; bb < eb; bb++) exp_dst[(j*eb+bb)*8 +: 8] = mem[8'(aj + 32'(bb))];
            end
        @(negedge clk);
        cur_ord = ord; cur_st = st; lifo_m = lifo; stall_m = stall;
        op_store = st; op_ordered = ord; base_addr = b; vlen = LW'(vl);
        data_wsel = dw; idx_wsel = iw; start = 1'b1;
        if (vl == 0) last_evt = cyc;
        t = 0; seen = 0;
        while (t < 500 && !seen) begin
            @(negedge clk);
            t++;
            start = (dbl && t == 2);
            if (dbl && t == 2) begin op_store = ~st; vlen = LW'(NE); end
            if (done) seen = 1;
        end
        start = 1'b0;
        if (!seen) begin
            chk(0, "R8 watchdog: done never rose", 0, 1);
        end else begin
            chk(cyc == last_evt + 1, "R8 done timing", 64'(cyc), 64'(last_evt + 1));
            chk(!busy, "R8 busy low with done", {63'h0, busy}, 0);
        end
        @(negedge clk);
        chk(!done && !busy, "R8 done single pulse", {62'h0, done, busy}, 0);
        chk(exp_q.size() == 0, "R5 all expected requests issued", 64'(exp_q.size()), 0);
        if (!st)
            for (int j = 0; j < NE; j++)
                chk(dst_vec[j*64 +: 64] == exp_dst[j*64 +: 64], "R7 destination vector",
                    dst_vec[j*64 +: 64], exp_dst[j*64 +: 64]);
        exp_q.delete();
        stall_m = 0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        for (int i = 0; i < NE; i++) begin ie[i] = '0; de[i] = '0; end
        repeat (3) @(negedge clk);
        chk(!busy && !done && !req_valid, "R1 state in reset", {61'h0, busy, done, req_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !req_valid, "R1 state after reset", {61'h0, busy, done, req_valid}, 0);

        // R5 R3 R4: ordered store, 8-bit offsets, 32-bit data, shared words not merged
        ie[0] = 0; ie[1] = 4; ie[2] = 12; ie[3] = 8;
        de[0] = 64'hA1A2A3A4; de[1] = 64'hB1B2B3B4; de[2] = 64'hC1C2C3C4; de[3] = 64'hD1D2D3D4;
        run_op(1, 1, 32'h20, 4, 2'd2, 2'd0, 0, 0, 0);

        // R2 R3 R5: ordered load, 16-bit offsets, 8-bit data, duplicates and a large offset
        ie[0] = 5; ie[1] = 5; ie[2] = 100; ie[3] = 0; ie[4] = 16'h00F0;
        run_op(0, 1, 32'h08, 5, 2'd0, 2'd1, 0, 0, 0);

        // R2 zero extension: 8-bit offset 0xF0 must not be sign-extended
        ie[0] = 64'hF0;
        exp_q.delete();
        run_op(0, 0, 32'h08, 1, 2'd0, 2'd0, 0, 0, 0);

        // R6 R7: unordered load, merging, responses returned last-in-first-out
        ie[0] = 3; ie[1] = 1; ie[2] = 2; ie[3] = 0; ie[4] = 9; ie[5] = 8; ie[6] = 20; ie[7] = 21;
        run_op(0, 0, 32'h40, 8, 2'd0, 2'd0, 1, 0, 0);

        // R6 R11: unordered store with overlapping lanes, 32-bit offsets, stalled port
        ie[0] = 2; ie[1] = 2; ie[2] = 6; ie[3] = 16;
        de[0] = 64'h1111; de[1] = 64'h2222; de[2] = 64'h3333; de[3] = 64'h4444;
        run_op(1, 0, 32'h80, 4, 2'd1, 2'd2, 0, 1, 0);

        // R6: read back, the later element of the overlapping pair must have won
        ie[0] = 2; ie[1] = 6; ie[2] = 16; ie[3] = 4;
        run_op(0, 1, 32'h80, 4, 2'd1, 2'd0, 0, 0, 0);
        chk(dst_vec[15:0] == 16'h2222, "R6 higher element wins overlap", {48'h0, dst_vec[15:0]}, 64'h2222);

        // R3 R7: unordered load, 64-bit offsets and data, out-of-order responses
        ie[0] = 16; ie[1] = 0; ie[2] = 64'h78;
        run_op(0, 0, 32'h00, 3, 2'd3, 2'd3, 1, 0, 0);

        // R9: zero active elements
        run_op(1, 0, 32'h00, 0, 2'd0, 2'd0, 0, 0, 0);

        // R10: second start during a busy store is ignored
        ie[0] = 0; ie[1] = 9; ie[2] = 18;
        de[0] = 64'h5A; de[1] = 64'h6B; de[2] = 64'h7C;
        run_op(1, 0, 32'h10, 3, 2'd0, 2'd0, 0, 1, 1);
        repeat (3) @(negedge clk);
        chk(!busy && !req_valid, "R10 no activity after ignored start", {62'h0, busy, req_valid}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        chk(0, "R8 global watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule